// File: doc/BRIEF.md
# Single-Drive Control Register with Service Watchdog

This block is the write-side control register for a floppy subsystem that has only one drive. A host write to the register's offset sets the drive motor, holds or releases the disk controller core's reset, and controls a service watchdog. When software writes to the two ignored offsets, nothing happens. Writes to any other offset are passed on, one cycle later, to the standard controller front-end through a forward strobe.

The watchdog lets software detect a drive operation that never completes. Software first sets the enable bit. It then starts the countdown by writing a value in which the trigger bit falls from 1 to 0 while the enable bit stays 1. If the countdown runs out, the watchdog interrupt is raised, provided the enable bit is still set. The interrupt stays high until software clears the enable bit or puts the controller back into reset. The timeout is set as a number of clock cycles. The default is three seconds at 100 MHz. A test setup can use a much smaller value.

Top module: `fdd_wdreg`

## Requirements
- R1: After reset the outputs are as follows: motorOn=0, coreReset=1, coreReady=0, tcClear=0, wdIrq=0 and fwdWr=0.
- R2: A write to offset 2 stores the register. From the next cycle, motorOn equals data bit 0 and coreReset equals the inverse of data bit 7. Bits 4:1 have no effect.
- R3: A write to offset 2 with bit 7 = 0 pulses coreReady for exactly one cycle. A write with bit 7 = 1 pulses tcClear for exactly one cycle.
- R4: A write to offset 2 with bit 5 (enable) = 0 stops any running countdown and drives wdIrq low from the next cycle.
- R5: A write to offset 2 with bit 5 = 1 and bit 6 (trigger) = 0 starts the countdown, but only if the stored bit 6 was 1. wdIrq is then low for TIMEOUT_CYC-1 cycles after that write and high from cycle TIMEOUT_CYC onward.
- R6: No other write starts the countdown. This covers a trigger that stays at 0, a trigger that rises, and a falling trigger with bit 5 = 0.
- R7: A new falling trigger edge while the countdown is running restarts it from the full TIMEOUT_CYC.
- R8: Once wdIrq is high, it stays high until a write to offset 2 with bit 5 = 0 or bit 7 = 0. Such a write clears it from the next cycle.
- R9: Writes to offsets 4 and 7 change no output. This includes the watchdog, which they neither start nor stop.
- R10: A write to offsets 0, 1, 3, 5 or 6 pulses fwdWr for one cycle, with fwdAddr and fwdData equal to the written address and data. A write to offset 2, 4 or 7 never pulses fwdWr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | 3 | Host write offset |
| wrData | input | 8 | Host write data |
| motorOn | output | 1 | Drive motor enable |
| coreReset | output | 1 | Reset to the controller core |
| coreReady | output | 1 | One-cycle ready strobe issued while the core is put in reset |
| tcClear | output | 1 | One-cycle strobe that clears the terminal count at the core |
| wdIrq | output | 1 | Watchdog timeout interrupt |
| fwdWr | output | 1 | Forwarded write strobe to the standard front-end |
| fwdAddr | output | 3 | Forwarded write offset |
| fwdData | output | 8 | Forwarded write data |

## Verification
Every register-driven result and every forwarded write appears in the cycle after the clock edge that samples the write. The bench therefore samples on the falling edge that follows that rising edge. The watchdog interrupt is due exactly TIMEOUT_CYC rising edges after the edge that sampled the starting write. The bench checks that it is still low after TIMEOUT_CYC-1 edges and high after TIMEOUT_CYC edges. For every value of the data byte written after each combination of previous trigger and enable, the bench predicts arithmetically whether the countdown starts. It uses a timeout of 12 cycles.

// File: rtl/fdd_wdreg_pkg.sv
package fdd_wdreg_pkg;

  localparam int BIT_MOTOR = 0;
  localparam int BIT_EN    = 5;
  localparam int BIT_TRIG  = 6;
  localparam int BIT_REL   = 7;

  // register bits that carry behaviour; bits 4:1 are not kept
  typedef struct packed {
    logic rstRel;
    logic trig;
    logic en;
    logic motor;
  } ctlBits_t;

  // strobes from control decode to datapath
  typedef struct packed {
    logic regWr;
    logic fwdWr;
    logic startWd;
    logic cancelWd;
    logic clrIrq;
    logic holdRst;
  } ctlStrobe_t;

endpackage

// File: rtl/fdd_wdreg_ctrl.sv
module fdd_wdreg_ctrl
  import fdd_wdreg_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int REG_ADDR = 2,
  parameter int IGN_A    = 4,
  parameter int IGN_B    = 7
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [2:0]        newBits,   // {release, trigger, enable}
  input  logic              prevTrig,
  output ctlStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(REG_ADDR);
  localparam logic [ADDR_W-1:0] IG_A  = ADDR_W'(IGN_A);
  localparam logic [ADDR_W-1:0] IG_B  = ADDR_W'(IGN_B);

  logic hitReg;
  logic hitIgn;
  logic newRel;
  logic newTrig;
  logic newEn;

  assign {newRel, newTrig, newEn} = newBits;
  assign hitReg = wrEn && (wrAddr == REG_A);
  assign hitIgn = (wrAddr == IG_A) || (wrAddr == IG_B);

  always_comb begin
    strobe          = '0;
    strobe.regWr    = hitReg;
    strobe.fwdWr    = wrEn && !hitIgn && (wrAddr != REG_A);
    strobe.cancelWd = hitReg && !newEn;
    strobe.startWd  = hitReg && newEn && !newTrig && prevTrig;
    strobe.clrIrq   = hitReg && (!newEn || !newRel);
    strobe.holdRst  = hitReg && !newRel;
  end

endmodule

// File: rtl/fdd_wdreg_dp.sv
module fdd_wdreg_dp
  import fdd_wdreg_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int TIMEOUT_CYC = 300_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output ctlBits_t          ctlQ,
  output logic              readyQ,
  output logic              tcClrQ,
  output logic              irqQ,
  output logic              fwdWrQ,
  output logic [ADDR_W-1:0] fwdAddrQ,
  output logic [DATA_W-1:0] fwdDataQ
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;
  logic             runQ;
  logic             expire;

  assign expire = runQ && (cntQ == CNT_ONE) && !strobe.startWd && !strobe.cancelWd;

  // register and strobe outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ     <= '0;
      readyQ   <= 1'b0;
      tcClrQ   <= 1'b0;
      fwdWrQ   <= 1'b0;
      fwdAddrQ <= '0;
      fwdDataQ <= '0;
    end else begin
      readyQ <= strobe.regWr && strobe.holdRst;
      tcClrQ <= strobe.regWr && !strobe.holdRst;
      fwdWrQ <= strobe.fwdWr;
      if (strobe.fwdWr) begin
        fwdAddrQ <= wrAddr;
        fwdDataQ <= wrData;
      end
      if (strobe.regWr) begin
        ctlQ.rstRel <= wrData[BIT_REL];
        ctlQ.trig   <= wrData[BIT_TRIG];
        ctlQ.en     <= wrData[BIT_EN];
        ctlQ.motor  <= wrData[BIT_MOTOR];
      end
    end
  end

  // watchdog countdown
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      runQ <= 1'b0;
    end else if (strobe.cancelWd) begin
      runQ <= 1'b0;
      cntQ <= '0;
    end else if (strobe.startWd) begin
      runQ <= 1'b1;
      cntQ <= CNT_LOAD;
    end else if (runQ) begin
      if (cntQ == CNT_ONE) begin
        runQ <= 1'b0;
        cntQ <= '0;
      end else begin
        cntQ <= cntQ - CNT_ONE;
      end
    end
  end

  // timeout interrupt, gated by the enable currently stored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ <= 1'b0;
    end else if (strobe.clrIrq) begin
      irqQ <= 1'b0;
    end else if (expire) begin
      irqQ <= ctlQ.en;
    end
  end

endmodule

// File: rtl/fdd_wdreg.sv
module fdd_wdreg
  import fdd_wdreg_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int REG_ADDR    = 2,
  parameter int IGN_A       = 4,
  parameter int IGN_B       = 7,
  parameter int TIMEOUT_CYC = 300_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              motorOn,
  output logic              coreReset,
  output logic              coreReady,
  output logic              tcClear,
  output logic              wdIrq,
  output logic              fwdWr,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [DATA_W-1:0] fwdData
);

  ctlStrobe_t strobe;
  ctlBits_t   ctlQ;

  fdd_wdreg_ctrl #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR),
    .IGN_A   (IGN_A),
    .IGN_B   (IGN_B)
  ) u_ctrl (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .newBits ({wrData[BIT_REL], wrData[BIT_TRIG], wrData[BIT_EN]}),
    .prevTrig(ctlQ.trig),
    .strobe  (strobe)
  );

  fdd_wdreg_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .ctlQ    (ctlQ),
    .readyQ  (coreReady),
    .tcClrQ  (tcClear),
    .irqQ    (wdIrq),
    .fwdWrQ  (fwdWr),
    .fwdAddrQ(fwdAddr),
    .fwdDataQ(fwdData)
  );

  assign motorOn   = ctlQ.motor;
  assign coreReset = !ctlQ.rstRel;

endmodule

// File: rtl/fdd_wdreg_chk.sv
module fdd_wdreg_chk #(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int REG_ADDR = 2,
  parameter int IGN_A    = 4,
  parameter int IGN_B    = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              motorOn,
  input logic              coreReset,
  input logic              coreReady,
  input logic              tcClear,
  input logic              wdIrq,
  input logic              fwdWr,
  input logic [DATA_W-1:0] fwdData,
  input logic              enStored
);

  logic regHit;
  logic ignHit;
  assign regHit = wrEn && (wrAddr == ADDR_W'(REG_ADDR));
  assign ignHit = wrEn && ((wrAddr == ADDR_W'(IGN_A)) || (wrAddr == ADDR_W'(IGN_B)));

  // R2
  p_reg_update_r2: assert property (@(posedge clk) disable iff (!rstN)
    regHit |=> (motorOn == $past(wrData[0])) && (coreReset == !$past(wrData[7])));

  // R3
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(coreReady && tcClear));

  // R4
  p_cancel_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regHit && !wrData[5]) |=> !wdIrq);

  // R8
  p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdIrq) |-> enStored);

  // R9
  p_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    ignHit |=> !fwdWr && $stable(motorOn) && $stable(coreReset) && !coreReady && !tcClear);

  // R10
  p_forward_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !regHit && !ignHit) |=> fwdWr && (fwdData == $past(wrData)));

endmodule

bind fdd_wdreg fdd_wdreg_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .REG_ADDR(REG_ADDR),
  .IGN_A   (IGN_A),
  .IGN_B   (IGN_B)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .motorOn  (motorOn),
  .coreReset(coreReset),
  .coreReady(coreReady),
  .tcClear  (tcClear),
  .wdIrq    (wdIrq),
  .fwdWr    (fwdWr),
  .fwdData  (fwdData),
  .enStored (ctlQ.en)
);

// File: tb/fdd_wdreg_test.sv
module fdd_wdreg_test;

  localparam int T = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       motorOn, coreReset, coreReady, tcClear, wdIrq, fwdWr;
  logic [2:0] fwdAddr;
  logic [7:0] fwdData;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  fdd_wdreg #(.TIMEOUT_CYC(T)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .motorOn(motorOn), .coreReset(coreReset), .coreReady(coreReady),
    .tcClear(tcClear), .wdIrq(wdIrq), .fwdWr(fwdWr), .fwdAddr(fwdAddr),
    .fwdData(fwdData)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the sampling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finishRun;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 motorOn", motorOn, 0);
    check("R1 coreReset", coreReset, 1);
    check("R1 coreReady", coreReady, 0);
    check("R1 tcClear", tcClear, 0);
    check("R1 wdIrq", wdIrq, 0);
    check("R1 fwdWr", fwdWr, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6: every data byte after each prior trigger/enable pair
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < 256; d++) begin
        logic [7:0] prev;
        logic [7:0] dv;
        int expStart;
        prev = 8'h80 | 8'(p << 5);
        dv = 8'(d);
        wr(3'd2, 8'h00);
        wr(3'd2, prev);
        wr(3'd2, dv);
        expStart = (dv[5] && !dv[6] && prev[6]) ? 1 : 0;
        check("R2 motorOn", motorOn, int'(dv[0]));
        check("R2 coreReset", coreReset, int'(!dv[7]));
        check("R3 coreReady", coreReady, int'(!dv[7]));
        check("R3 tcClear", tcClear, int'(dv[7]));
        check("R10 no fwd on reg", fwdWr, 0);
        check("R4 irq after write", wdIrq, 0);
        waitN(1);
        check("R3 coreReady one cycle", coreReady, 0);
        check("R3 tcClear one cycle", tcClear, 0);
        waitN(T - 2);
        check("R5 irq not early", wdIrq, 0);
        waitN(1);
        check(expStart ? "R5 irq on time" : "R6 no start", wdIrq, expStart);
      end
    end

    // R7 retrigger restarts the full count
    wr(3'd2, 8'h00);
    wr(3'd2, 8'hE0);
    wr(3'd2, 8'hA0);
    waitN(5);
    wr(3'd2, 8'hE0);
    wr(3'd2, 8'hA0);
    waitN(T - 1);
    check("R7 restarted irq not early", wdIrq, 0);
    waitN(1);
    check("R7 restarted irq on time", wdIrq, 1);

    // R8 persistence and clear by reset hold
    waitN(20);
    check("R8 irq held", wdIrq, 1);
    wr(3'd2, 8'hA1);
    check("R8 irq held after benign write", wdIrq, 1);
    wr(3'd2, 8'h21);
    check("R8 irq cleared by bit7=0", wdIrq, 0);

    // R4 cancel during countdown
    wr(3'd2, 8'hE0);
    wr(3'd2, 8'hA0);
    waitN(3);
    wr(3'd2, 8'h80);
    waitN(T + 2);
    check("R4 cancelled count", wdIrq, 0);

    // R9 ignored offsets: no output change, no start, no cancel
    wr(3'd2, 8'hE1);
    wr(3'd4, 8'hA0);
    check("R9 fwd off4", fwdWr, 0);
    check("R9 motor off4", motorOn, 1);
    check("R9 reset off4", coreReset, 0);
    wr(3'd7, 8'h00);
    check("R9 fwd off7", fwdWr, 0);
    check("R9 motor off7", motorOn, 1);
    check("R9 tcClear off7", tcClear, 0);
    waitN(T + 2);
    check("R9 no start from ignored", wdIrq, 0);
    wr(3'd2, 8'hA1);
    wr(3'd7, 8'h00);
    waitN(T);
    check("R9 no cancel from ignored", wdIrq, 1);

    // R10 forwarding per offset
    for (int a = 0; a < 8; a++) begin
      logic [7:0] dv;
      int expF;
      dv = 8'h5A ^ 8'(a * 17);
      expF = (a == 2 || a == 4 || a == 7) ? 0 : 1;
      wr(3'(a), dv);
      check("R10 fwdWr", fwdWr, expF);
      if (expF == 1) begin
        check("R10 fwdAddr", fwdAddr, a);
        check("R10 fwdData", fwdData, dv);
      end
      waitN(1);
      check("R10 fwdWr one cycle", fwdWr, 0);
    end

    finishRun();
  end

endmodule